// File: doc/BRIEF.md
# Masked NIC Interrupt Status Controller

This block holds the interrupt state of a small packet-buffer Ethernet controller. It keeps an 8-bit status register and an 8-bit mask register. It drives one registered, level-sensitive interrupt line that is high while any unmasked status bit is set.

Status bits come from three kinds of source:
- Two bits follow queue state. One shows the transmit queue is empty; the other shows the transmit-completion queue holds entries.
- The remaining bits latch single-cycle event pulses from the receive, allocation, overrun and link logic.
- The receive bit also follows receive-queue pops.

The host clears bits through a write-one-to-acknowledge port. Only a fixed subset of bits responds to it. Acknowledging the transmit-done bit also sends a pop request to the completion queue. The queues, packet memory and bus decode sit outside this block and are seen only as flags, pulses and the pop request.

Top module: `nic_irq_ctrl`

## Requirements
- R1: Status bit positions are: 7 link event, 6 early receive, 5 PHY event, 4 receive overrun, 3 allocation done, 2 transmit empty, 1 transmit done, 0 receive. During and right after a synchronous reset, status reads 0x04, mask reads 0x00, and `irq` and `done_pop` are low.
- R2: `irq` is high exactly when `status & mask` is non-zero, and it is valid in the same cycle as both registers.
- R3: Bit 2 is set in every cycle that follows a cycle with `tx_q_empty` high, whatever acknowledge arrives.
- R4: Bit 1 is set in every cycle that follows a cycle with `done_q_nonempty` high, whatever acknowledge arrives.
- R5: An acknowledge write clears the status bits selected by `ack_data & 0xD6`, which are bits 7, 6, 4, 2 and 1, in the next cycle.
- R6: An acknowledge write never clears bits 5, 3 or 0.
- R7: An acknowledge write with bit 1 set, issued while `done_q_nonempty` is high, gives exactly one `done_pop` pulse in the next cycle. `done_pop` stays low in every other case.
- R8: A high bit of `evt_set` sets the matching status bit in the next cycle. This holds even when an acknowledge or a pop-clear targets the same bit in the same cycle.
- R9: A receive-queue pop (`rx_pop`) sets bit 0 when `rx_remain` is high and clears it when `rx_remain` is low.
- R10: A mask write loads `mask_data` into the mask in the next cycle. That value drives `irq` in the same cycle.
- R11: With no event, acknowledge, pop or mask write, status and mask keep their values, apart from the forced bits of R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 8 | Single-cycle set pulses, one per status bit |
| tx_q_empty | input | 1 | Transmit queue holds no entries |
| done_q_nonempty | input | 1 | Transmit-completion queue holds entries |
| rx_pop | input | 1 | Receive queue pop taking place this cycle |
| rx_remain | input | 1 | Receive queue still holds entries after this pop |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Acknowledge value, one bit per status bit |
| mask_we | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask value |
| status | output | 8 | Interrupt status register |
| mask | output | 8 | Interrupt mask register |
| irq | output | 1 | Level interrupt request |
| done_pop | output | 1 | Pop request to the transmit-completion queue |

## Verification
The assertions check the following on every cycle:
- the interrupt level against status and mask;
- the two forced queue bits;
- that event pulses win over clears;
- the stickiness of the bits that cannot be acknowledged;
- the exact conditions for a completion-queue pop;
- mask loading and holding.

The bench scenarios cover the rest:
- exact status values after mixed acknowledges, including the 0xD6 subset;
- the receive-pop behaviour with and without entries remaining;
- the pop pulse lasting one cycle while the done bit stays forced;
- the reset values.

A behavioural reference model also compares every output on every cycle, during both directed and random traffic.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int STAT_W      = 8;
  localparam int IB_RCV      = 0;
  localparam int IB_TX_DONE  = 1;
  localparam int IB_TX_EMPTY = 2;
  localparam int IB_ALLOC    = 3;
  localparam int IB_OVERRUN  = 4;
  localparam int IB_PHY      = 5;
  localparam int IB_EARLY_RX = 6;
  localparam int IB_LINK     = 7;
  localparam logic [STAT_W-1:0] ACK_MASK_DEF = 8'hD6;
  localparam logic [STAT_W-1:0] RST_STAT_DEF = 8'h04;
endpackage

// File: rtl/nic_irq_stat_bit.sv
module nic_irq_stat_bit #(
  parameter bit ACKABLE = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic ack_i,
  input  logic clr_i,
  input  logic force_i,
  output logic d_o,
  output logic q_o
);
  logic ack_eff;

  assign ack_eff = ack_i & ACKABLE;

  // set pulses and forced conditions win over any clear
  always_comb begin
    d_o = force_i | set_i | (q_o & ~ack_eff & ~clr_i);
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/nic_irq_mask_reg.sv
module nic_irq_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);
  always_comb d_o = we ? wdata : q_o;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_o;
  end
endmodule

// File: rtl/nic_irq_out.sv
module nic_irq_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_d,
  input  logic [W-1:0] mask_d,
  input  logic         pop_req,
  output logic         irq_o,
  output logic         pop_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o <= 1'b0;
      pop_o <= 1'b0;
    end else begin
      irq_o <= |(stat_d & mask_d);
      pop_o <= pop_req;
    end
  end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int                 W        = STAT_W,
  parameter logic [STAT_W-1:0]  ACK_MASK = ACK_MASK_DEF,
  parameter logic [STAT_W-1:0]  RST_STAT = RST_STAT_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_set,
  input  logic         tx_q_empty,
  input  logic         done_q_nonempty,
  input  logic         rx_pop,
  input  logic         rx_remain,
  input  logic         ack_we,
  input  logic [W-1:0] ack_data,
  input  logic         mask_we,
  input  logic [W-1:0] mask_data,
  output logic [W-1:0] status,
  output logic [W-1:0] mask,
  output logic         irq,
  output logic         done_pop
);
  logic [W-1:0] set_vec;
  logic [W-1:0] ack_vec;
  logic [W-1:0] clr_vec;
  logic [W-1:0] force_vec;
  logic [W-1:0] stat_d;
  logic [W-1:0] mask_d;
  logic         pop_req;

  always_comb begin
    set_vec            = evt_set;
    set_vec[IB_RCV]    = evt_set[IB_RCV] | (rx_pop & rx_remain);
    clr_vec            = '0;
    clr_vec[IB_RCV]    = rx_pop & ~rx_remain;
    ack_vec            = ack_we ? ack_data : '0;
    force_vec              = '0;
    force_vec[IB_TX_EMPTY] = tx_q_empty;
    force_vec[IB_TX_DONE]  = done_q_nonempty;
    pop_req = ack_we & ack_data[IB_TX_DONE] & done_q_nonempty;
  end

  for (genvar k = 0; k < W; k++) begin : g_bit
    nic_irq_stat_bit #(
      .ACKABLE (ACK_MASK[k]),
      .RST_VAL (RST_STAT[k])
    ) u_bit (
      .clk     (clk),
      .rst     (rst),
      .set_i   (set_vec[k]),
      .ack_i   (ack_vec[k]),
      .clr_i   (clr_vec[k]),
      .force_i (force_vec[k]),
      .d_o     (stat_d[k]),
      .q_o     (status[k])
    );
  end

  nic_irq_mask_reg #(.W(W)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we    (mask_we),
    .wdata (mask_data),
    .d_o   (mask_d),
    .q_o   (mask)
  );

  nic_irq_out #(.W(W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .stat_d  (stat_d),
    .mask_d  (mask_d),
    .pop_req (pop_req),
    .irq_o   (irq),
    .pop_o   (done_pop)
  );
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] evt_set,
  input logic         tx_q_empty,
  input logic         done_q_nonempty,
  input logic         rx_pop,
  input logic         rx_remain,
  input logic         ack_we,
  input logic [W-1:0] ack_data,
  input logic         mask_we,
  input logic [W-1:0] mask_data,
  input logic [W-1:0] status,
  input logic [W-1:0] mask,
  input logic         irq,
  input logic         done_pop
);
  // R2
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status & mask)));

  // R3
  tx_empty_force_chk: assert property (@(posedge clk) disable iff (rst)
    tx_q_empty |=> status[2]);

  // R4
  tx_done_force_chk: assert property (@(posedge clk) disable iff (rst)
    done_q_nonempty |=> status[1]);

  // R7
  pop_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we && ack_data[1] && done_q_nonempty) |=> done_pop);

  // R7
  pop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(ack_we && ack_data[1] && done_q_nonempty) |=> !done_pop);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_set) |=> ((status & $past(evt_set)) == $past(evt_set)));

  // R6
  phy_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status[5] |=> status[5]);

  // R6
  alloc_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status[3] |=> status[3]);

  // R9
  rcv_pop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_pop && !rx_remain && !evt_set[0]) |=> !status[0]);

  // R9
  rcv_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !(rx_pop && !rx_remain)) |=> status[0]);

  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> (mask == $past(mask_data)));

  // R11
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask));
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/nic_irq_ctrl_bench.sv
module nic_irq_ctrl_bench;
  localparam int W = 8;
  localparam int WATCHDOG_CYC = 20000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] evt_set = '0;
  logic         tx_q_empty = 1'b1;
  logic         done_q_nonempty = 1'b0;
  logic         rx_pop = 1'b0;
  logic         rx_remain = 1'b0;
  logic         ack_we = 1'b0;
  logic [W-1:0] ack_data = '0;
  logic         mask_we = 1'b0;
  logic [W-1:0] mask_data = '0;
  logic [W-1:0] status;
  logic [W-1:0] mask;
  logic         irq;
  logic         done_pop;

  int checks = 0;
  int fails  = 0;
  bit model_on = 1'b0;
  bit done_run = 1'b0;

  logic [7:0] m_stat = 8'h04;
  logic [7:0] m_mask = 8'h00;
  logic       m_irq  = 1'b0;
  logic       m_pop  = 1'b0;

  always #5 clk = ~clk;

  nic_irq_ctrl u_nic_irq_ctrl (
    .clk(clk), .rst(rst), .evt_set(evt_set), .tx_q_empty(tx_q_empty),
    .done_q_nonempty(done_q_nonempty), .rx_pop(rx_pop), .rx_remain(rx_remain),
    .ack_we(ack_we), .ack_data(ack_data), .mask_we(mask_we),
    .mask_data(mask_data), .status(status), .mask(mask), .irq(irq),
    .done_pop(done_pop)
  );

  // behavioural reference, evaluated on the same edge as the design
  always @(posedge clk) begin
    logic [7:0] ns;
    logic [7:0] nm;
    if (rst) begin
      m_stat = 8'h04; m_mask = 8'h00; m_irq = 1'b0; m_pop = 1'b0;
    end else begin
      ns = m_stat;
      if (ack_we) ns = ns & ~(ack_data & 8'hD6);
      if (rx_pop) begin
        if (rx_remain) ns[0] = 1'b1;
        else           ns[0] = 1'b0;
      end
      ns = ns | evt_set;
      if (tx_q_empty)      ns[2] = 1'b1;
      if (done_q_nonempty) ns[1] = 1'b1;
      nm = mask_we ? mask_data : m_mask;
      m_pop  = ack_we && ack_data[1] && done_q_nonempty;
      m_stat = ns;
      m_mask = nm;
      m_irq  = (ns & nm) != 8'h00;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R8 status vs model", status, m_stat);
      chk("R10 mask vs model", mask, m_mask);
      chk("R2 irq vs model", {7'd0, irq}, {7'd0, m_irq});
      chk("R7 done_pop vs model", {7'd0, done_pop}, {7'd0, m_pop});
    end
  end

  task automatic quiet();
    evt_set = '0; rx_pop = 1'b0; rx_remain = 1'b0;
    ack_we = 1'b0; ack_data = '0; mask_we = 1'b0; mask_data = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done_run) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    quiet();
    tick(); tick();
    chk("R1 status in reset", status, 8'h04);
    chk("R1 mask in reset", mask, 8'h00);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    chk("R1 done_pop in reset", {7'd0, done_pop}, 8'h00);
    rst = 1'b0; model_on = 1'b1;
    tick();
    chk("R1 status after reset", status, 8'h04);

    // R10 / R2: unmask transmit-empty
    mask_we = 1'b1; mask_data = 8'h04; tick(); quiet();
    chk("R10 mask load", mask, 8'h04);
    chk("R2 irq on unmasked bit", {7'd0, irq}, 8'h01);

    // R5: acknowledge transmit-empty once queue is no longer empty
    tx_q_empty = 1'b0; ack_we = 1'b1; ack_data = 8'h04; tick(); quiet();
    chk("R5 ack clears bit 2", status, 8'h00);
    chk("R2 irq drops", {7'd0, irq}, 8'h00);

    // R3: forced bit beats acknowledge
    tx_q_empty = 1'b1; ack_we = 1'b1; ack_data = 8'h04; tick(); quiet();
    chk("R3 tx empty forced", status, 8'h04);
    tx_q_empty = 1'b0; ack_we = 1'b1; ack_data = 8'h04; tick(); quiet();
    chk("R5 bit 2 cleared again", status, 8'h00);

    // R4 / R7
    done_q_nonempty = 1'b1; tick();
    chk("R4 tx done forced", status, 8'h02);
    ack_we = 1'b1; ack_data = 8'h02; tick(); quiet();
    chk("R7 pop pulse", {7'd0, done_pop}, 8'h01);
    chk("R4 done bit held by queue", status, 8'h02);
    tick();
    chk("R7 pop lasts one cycle", {7'd0, done_pop}, 8'h00);
    done_q_nonempty = 1'b0; ack_we = 1'b1; ack_data = 8'h02; tick(); quiet();
    chk("R7 no pop on empty queue", {7'd0, done_pop}, 8'h00);
    chk("R5 done bit cleared", status, 8'h00);

    // R8 / R5 / R6
    evt_set = 8'hF9; tick(); quiet();
    chk("R8 events set", status, 8'hF9);
    ack_we = 1'b1; ack_data = 8'hFF; tick(); quiet();
    chk("R6 bits 5 3 0 survive ack", status, 8'h29);
    evt_set = 8'h80; ack_we = 1'b1; ack_data = 8'h80; tick(); quiet();
    chk("R8 set beats ack", status, 8'hA9);

    // R9
    rx_pop = 1'b1; rx_remain = 1'b1; tick(); quiet();
    chk("R9 pop with entries left", status, 8'hA9);
    rx_pop = 1'b1; rx_remain = 1'b0; tick(); quiet();
    chk("R9 pop empties queue", status, 8'hA8);
    rx_pop = 1'b1; rx_remain = 1'b0; evt_set = 8'h01; tick(); quiet();
    chk("R8 set beats pop clear", status, 8'hA9);

    // R11
    repeat (3) tick();
    chk("R11 status holds", status, 8'hA9);
    chk("R11 mask holds", mask, 8'h04);

    // R2 with mask changes
    mask_we = 1'b1; mask_data = 8'h00; tick(); quiet();
    chk("R2 fully masked", {7'd0, irq}, 8'h00);
    mask_we = 1'b1; mask_data = 8'h20; tick(); quiet();
    chk("R2 phy bit unmasked", {7'd0, irq}, 8'h01);

    // random traffic, compared against the model each cycle
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      evt_set         = (r[3:0] == 4'd0) ? r[11:4] : 8'h00;
      tx_q_empty      = r[12];
      done_q_nonempty = r[13] & r[14];
      rx_pop          = (r[17:15] == 3'd0);
      rx_remain       = r[18];
      ack_we          = (r[20:19] == 2'd0);
      ack_data        = r[28:21];
      mask_we         = (r[31:29] == 3'd0);
      mask_data       = r[27:20];
      tick();
    end
    quiet();
    tick();

    done_run = 1'b1;
    summary();
    $finish;
  end
endmodule